// File: doc/BRIEF.md
# Region Address Translation Matcher

This block maps a 32-bit virtual address onto a physical address through a small set of fixed-region translation entries. Each entry is a pair of 32-bit words. The tag word holds the region's virtual base, a size field and an enable bit. The target word holds the physical base. Software loads the words through a narrow write port that names the entry and the word.

When a request arrives, every entry compares the address with its tag above a region boundary. That boundary is 128 KB at minimum and widens as the size field grows. Address bits below the boundary are passed straight through to the result. The lowest-numbered entry that matches supplies the physical base.

The answer is registered and appears one cycle after the request, together with a one-cycle valid pulse. It reports whether an entry matched, which entry matched, and the translated address. A miss reads back as all ones with the hit flag low.

Top module: `region_xlat`

## Requirements
- R1: After reset every entry is disabled, so any request made before an entry is written reports a miss.
- R2: A write with `cfg_we` high stores `cfg_data` into entry `cfg_idx`. `cfg_tag_sel`=1 selects the tag word and 0 selects the target word. The value is used from the next cycle on, and the other word and the other entries are unchanged.
- R3: Bit 1 of the tag word is the enable bit. An entry whose enable bit is 0 never matches.
- R4: Address bits [16:0] are never compared. On a match they are copied unchanged from the request address into the result.
- R5: Tag bits [9:2] are the size field, which must be a contiguous run of ones from bit 2 upward. A size value S makes address bits [16+k:17] uncompared and passed through, where k is the number of ones in S. For example, S=0x0F gives a 2 MB region and S=0xFF gives a 32 MB region.
- R6: An entry matches when its tag word equals the request address on every compared bit. On a match, the result takes its compared bits from the target word and its other bits from the address.
- R7: When several entries match, the one with the lowest index wins. `rsp_entry` reports that index.
- R8: On a miss, `rsp_hit` is 0, `rsp_addr` is 0xFFFFFFFF and `rsp_entry` is 0.
- R9: `rsp_valid` is high for exactly the cycle after each cycle in which `req_valid` is high. The response outputs hold their values between requests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Entry word write enable |
| cfg_idx | input | 2 | Entry index to write |
| cfg_tag_sel | input | 1 | 1 = tag word, 0 = target word |
| cfg_data | input | 32 | Word value to write |
| req_valid | input | 1 | Translation request strobe |
| req_addr | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | Response valid pulse |
| rsp_hit | output | 1 | An entry matched |
| rsp_addr | output | 32 | Translated address, all ones on a miss |
| rsp_entry | output | 2 | Index of the winning entry |

## Verification
Four entries are loaded so that their regions are 128 KB, 2 MB and 32 MB in size and overlap. The fourth entry is disabled. The table of addresses is chosen to tell the matching cases apart:
- an address at the edge of the 128 KB region separates the fixed pass-through width from the variable one;
- an address one bit outside the 2 MB region shows that the size field, and not a fixed width, sets the compare boundary;
- an address inside both the 128 KB and the 32 MB regions separates lowest-index priority from any other ordering.

Directed tests then cover the miss right after reset, clearing an enable bit so that a lower-priority entry takes over, and rewriting only the target word. They also check that the response outputs hold between requests.

// File: rtl/region_xlat_pkg.sv
package region_xlat_pkg;
  // Address and tag word width.
  parameter int ADDR_W    = 32;
  // Bits below this boundary are never compared.
  parameter int BASE_BITS = 17;
  // Size field position and width inside the tag word.
  parameter int SIZE_LSB  = 2;
  parameter int SIZE_W    = 8;
  // Enable bit position inside the tag word.
  parameter int EN_POS    = 1;

  typedef logic [ADDR_W-1:0] word_t;

  // Mask of compared bits: ones where tag and address must agree.
  function automatic word_t cmp_mask(input word_t tag);
    word_t dont_care;
    word_t size_bits;
    dont_care = '0;
    dont_care[BASE_BITS-1:0] = '1;
    size_bits = '0;
    size_bits[SIZE_W-1:0] = tag[SIZE_LSB +: SIZE_W];
    dont_care = dont_care | (size_bits << BASE_BITS);
    return ~dont_care;
  endfunction

  function automatic logic tag_match(input word_t tag, input word_t addr);
    word_t m;
    m = cmp_mask(tag);
    return tag[EN_POS] && ((tag & m) == (addr & m));
  endfunction

  function automatic word_t merge_addr(input word_t tgt, input word_t addr, input word_t m);
    return (tgt & m) | (addr & ~m);
  endfunction
endpackage

// File: rtl/region_xlat_regs.sv
module region_xlat_regs
  import region_xlat_pkg::*;
#(
  parameter int N_ENTRIES = 4,
  localparam int IW = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [IW-1:0]           cfg_idx,
  input  logic                    cfg_tag_sel,
  input  word_t                   cfg_data,
  output logic [N_ENTRIES-1:0][ADDR_W-1:0] tag_q,
  output logic [N_ENTRIES-1:0][ADDR_W-1:0] tgt_q
);
  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
    logic sel;
    assign sel = cfg_we && (int'(cfg_idx) == g);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tag_q[g] <= '0;
        tgt_q[g] <= '0;
      end else if (sel) begin
        if (cfg_tag_sel) tag_q[g] <= cfg_data;
        else             tgt_q[g] <= cfg_data;
      end
    end
  end
endmodule

// File: rtl/region_xlat_entry.sv
module region_xlat_entry
  import region_xlat_pkg::*;
(
  input  word_t tag,
  input  word_t tgt,
  input  word_t addr,
  output logic  hit,
  output word_t xlat
);
  word_t m;
  assign m    = cmp_mask(tag);
  assign hit  = tag_match(tag, addr);
  assign xlat = merge_addr(tgt, addr, m);
endmodule

// File: rtl/region_xlat_pick.sv
module region_xlat_pick
  import region_xlat_pkg::*;
#(
  parameter int N_ENTRIES = 4,
  localparam int IW = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic [N_ENTRIES-1:0]             hit_vec,
  input  logic [N_ENTRIES-1:0][ADDR_W-1:0] xlat_vec,
  output logic                             any_hit,
  output logic [IW-1:0]                    win_idx,
  output word_t                            win_addr,
  output logic [N_ENTRIES-1:0]             win_vec
);
  always_comb begin
    any_hit  = 1'b0;
    win_idx  = '0;
    win_addr = '1;
    win_vec  = '0;
    for (int i = 0; i < N_ENTRIES; i++) begin
      if (hit_vec[i] && !any_hit) begin
        any_hit    = 1'b1;
        win_idx    = IW'(i);
        win_addr   = xlat_vec[i];
        win_vec[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/region_xlat.sv
module region_xlat
  import region_xlat_pkg::*;
#(
  parameter int N_ENTRIES = 4,
  localparam int IW = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [IW-1:0]        cfg_idx,
  input  logic                 cfg_tag_sel,
  input  logic [ADDR_W-1:0]    cfg_data,
  input  logic                 req_valid,
  input  logic [ADDR_W-1:0]    req_addr,
  output logic                 rsp_valid,
  output logic                 rsp_hit,
  output logic [ADDR_W-1:0]    rsp_addr,
  output logic [IW-1:0]        rsp_entry
);
  logic [N_ENTRIES-1:0][ADDR_W-1:0] tag_q, tgt_q, xlat_vec;
  logic [N_ENTRIES-1:0]             hit_vec, win_vec, en_vec;
  logic                             any_hit;
  logic [IW-1:0]                    win_idx;
  word_t                            win_addr;

  region_xlat_regs #(.N_ENTRIES(N_ENTRIES)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_tag_sel(cfg_tag_sel), .cfg_data(cfg_data),
    .tag_q(tag_q), .tgt_q(tgt_q)
  );

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
    region_xlat_entry u_ent (
      .tag(tag_q[g]), .tgt(tgt_q[g]), .addr(req_addr),
      .hit(hit_vec[g]), .xlat(xlat_vec[g])
    );
    assign en_vec[g] = tag_q[g][EN_POS];
  end

  region_xlat_pick #(.N_ENTRIES(N_ENTRIES)) u_pick (
    .hit_vec(hit_vec), .xlat_vec(xlat_vec), .any_hit(any_hit),
    .win_idx(win_idx), .win_addr(win_addr), .win_vec(win_vec)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_addr  <= '1;
      rsp_entry <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_hit   <= any_hit;
        rsp_addr  <= any_hit ? win_addr : '1;
        rsp_entry <= any_hit ? win_idx : '0;
      end
    end
  end
endmodule

// File: rtl/region_xlat_chk.sv
module region_xlat_chk
  import region_xlat_pkg::*;
#(
  parameter int N_ENTRIES = 4,
  parameter int IW = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic [ADDR_W-1:0]    req_addr,
  input logic                 rsp_valid,
  input logic                 rsp_hit,
  input logic [ADDR_W-1:0]    rsp_addr,
  input logic [IW-1:0]        rsp_entry,
  input logic [N_ENTRIES-1:0] hit_vec,
  input logic [N_ENTRIES-1:0] en_vec,
  input logic [N_ENTRIES-1:0] win_vec
);
  assert_rsp_follows_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_no_stray_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  assert_low_bits_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid ##1 (rsp_valid && rsp_hit)) |->
      rsp_addr[BASE_BITS-1:0] == $past(req_addr[BASE_BITS-1:0]));
  assert_miss_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_addr == '1 && rsp_entry == '0));
  assert_disabled_never_hits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec & ~en_vec) == '0);
  assert_one_winner_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_vec) && ((win_vec & ~hit_vec) == '0));
endmodule

bind region_xlat region_xlat_chk #(.N_ENTRIES(N_ENTRIES), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_addr(rsp_addr),
  .rsp_entry(rsp_entry), .hit_vec(hit_vec), .en_vec(en_vec), .win_vec(win_vec)
);

// File: tb/sim_region_xlat.sv
module sim_region_xlat;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we, cfg_tag_sel, req_valid;
  logic [1:0]  cfg_idx;
  logic [31:0] cfg_data, req_addr;
  logic        rsp_valid, rsp_hit;
  logic [31:0] rsp_addr;
  logic [1:0]  rsp_entry;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  region_xlat u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_tag_sel(cfg_tag_sel), .cfg_data(cfg_data), .req_valid(req_valid),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_addr(rsp_addr), .rsp_entry(rsp_entry)
  );

  typedef struct packed {
    logic [31:0] a;
    logic        h;
    logic [1:0]  e;
    logic [31:0] r;
  } vec_t;

  // Entries: 0 = 128 KB @0x10000000->0x80000000, 1 = 2 MB @0x20000000->0x40200000,
  // 2 = 32 MB @0x10000000->0xA0000000, 3 = disabled @0x30000000.
  localparam vec_t VECS [8] = '{
    '{32'h1000_1234, 1'b1, 2'd0, 32'h8000_1234},  // R6 R7: entry 0 beats entry 2
    '{32'h1001_FFFF, 1'b1, 2'd0, 32'h8001_FFFF},  // R4: top of 128 KB
    '{32'h1002_0000, 1'b1, 2'd2, 32'hA002_0000},  // R5: bit 17 leaves entry 0
    '{32'h201F_FFFF, 1'b1, 2'd1, 32'h403F_FFFF},  // R5: 2 MB size
    '{32'h2020_0000, 1'b0, 2'd0, 32'hFFFF_FFFF},  // R5 R8: bit 21 compared
    '{32'h11FF_FFFF, 1'b1, 2'd2, 32'hA1FF_FFFF},  // R5: 32 MB size
    '{32'h3000_0000, 1'b0, 2'd0, 32'hFFFF_FFFF},  // R3: disabled entry
    '{32'h0001_0000, 1'b0, 2'd0, 32'hFFFF_FFFF}   // R8: no region
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] idx, input logic sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_tag_sel = sel; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Request at a negedge; response is sampled at the following negedge.
  task automatic req(input logic [31:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_rsp(input string tag, input logic h, input logic [1:0] e,
                            input logic [31:0] r);
    chk({tag, " valid"}, {31'd0, rsp_valid}, 32'd1);
    chk({tag, " hit"},   {31'd0, rsp_hit},   {31'd0, h});
    chk({tag, " entry"}, {30'd0, rsp_entry}, {30'd0, e});
    chk({tag, " addr"},  rsp_addr, r);
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_tag_sel = 1'b0;
    cfg_data = '0; req_valid = 1'b0; req_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R9 reset valid", {31'd0, rsp_valid}, 32'd0);
    chk("R8 reset hit",   {31'd0, rsp_hit},   32'd0);

    // R1: reset leaves entries disabled, even for a tag-equal address of 0.
    req(32'h0000_0000);
    expect_rsp("R1 post-reset", 1'b0, 2'd0, 32'hFFFF_FFFF);

    wr(2'd0, 1'b1, 32'h1000_0002);
    wr(2'd0, 1'b0, 32'h8000_0000);
    wr(2'd1, 1'b1, 32'h2000_003E);
    wr(2'd1, 1'b0, 32'h4020_0000);
    wr(2'd2, 1'b1, 32'h1000_03FE);
    wr(2'd2, 1'b0, 32'hA000_0000);
    wr(2'd3, 1'b1, 32'h3000_0000);
    wr(2'd3, 1'b0, 32'h5000_0000);

    for (int i = 0; i < 8; i++) begin
      req(VECS[i].a);
      expect_rsp($sformatf("R6 vec%0d", i), VECS[i].h, VECS[i].e, VECS[i].r);
    end

    // R9: pulse drops and outputs hold.
    @(negedge clk);
    chk("R9 pulse low", {31'd0, rsp_valid}, 32'd0);
    chk("R9 hold addr", rsp_addr, 32'hFFFF_FFFF);

    // R2: target-only rewrite of entry 1.
    wr(2'd1, 1'b0, 32'h6000_0000);
    req(32'h201F_FFFF);
    expect_rsp("R2 target rewrite", 1'b1, 2'd1, 32'h601F_FFFF);

    // R3: disable entry 0; entry 2 now serves its region.
    wr(2'd0, 1'b1, 32'h1000_0000);
    req(32'h1000_1234);
    expect_rsp("R3 disabled", 1'b1, 2'd2, 32'hA000_1234);

    // R9: back-to-back requests.
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h201F_0000;
    @(negedge clk);
    expect_rsp("R9 b2b first", 1'b1, 2'd1, 32'h601F_0000);
    req_addr = 32'h0000_0000;
    @(negedge clk);
    req_valid = 1'b0;
    expect_rsp("R9 b2b second", 1'b0, 2'd0, 32'hFFFF_FFFF);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule